// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for each arriving Ethernet frame, whether to keep it. The decision rests only on the 48-bit destination address. The receive path presents that address one byte per cycle. The block stores a station address, a 64-entry multicast hash table and four mode bits, all set through a small write port. From the address it computes a CRC-32, and it reports accept or reject along with a one-hot class: unicast, multicast or broadcast.

A frame begins with a start strobe that arrives together with its first address byte. After the sixth byte the result appears on the next cycle. It stays there until the next start strobe, so the downstream frame logic can sample it whenever it likes.

Top module: `rx_da_filter`

## Requirements
- R1: Writes use `cfg_addr` to pick a register: 0 holds the upper station half (`cfg_wdata[15:8]` = address byte 0, `[7:0]` = byte 1); 1 holds the lower half (`[31:24]` = byte 2 down to `[7:0]` = byte 5); 2 holds hash entries 0..31; 3 holds hash entries 32..63; 4 holds the mode bits (bit 0 promiscuous, bit 1 all-group, bit 2 hash enable, bit 3 broadcast accept).
- R2: After reset, the station address and the hash table are zero, the mode is broadcast accept only, and `dec_valid` and all result flags are 0.
- R3: `da_start` must come with the first byte. A byte is taken in every cycle that has `da_valid` high, until six have been taken; idle cycles between bytes are allowed; further bytes are ignored until the next `da_start`.
- R4: `dec_valid` rises one cycle after the sixth byte is taken. The result stays stable until a `da_start`, which clears `dec_valid` on the following cycle.
- R5: Exactly one class flag is set while `dec_valid` is high: broadcast if all 48 bits are 1; otherwise multicast if bit 0 of byte 0 is 1; otherwise unicast.
- R6: A unicast frame is accepted only when all 48 bits equal the station address, unless promiscuous mode is set.
- R7: A broadcast frame is accepted when broadcast accept is set.
- R8: In promiscuous mode every frame is accepted.
- R9: In all-group mode every multicast or broadcast frame is accepted.
- R10: With hash enable set, a multicast frame is accepted when its hash table entry is 1. The entry index is bits 31..26 of a CRC-32 computed over bytes 0..5 in arrival order, each byte bit 0 first. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones and has no final inversion.
- R11: A hash index of 32 or more selects bit (index-32) of register 3; a smaller index selects bit index of register 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Write data |
| da_start | input | 1 | First byte of a new address |
| da_valid | input | 1 | Address byte valid |
| da_byte | input | 8 | Address byte, byte 0 first |
| dec_valid | output | 1 | Decision available |
| dec_accept | output | 1 | Frame accepted |
| dec_ucast | output | 1 | Unicast class |
| dec_mcast | output | 1 | Multicast (non-broadcast group) class |
| dec_bcast | output | 1 | Broadcast class |

## Verification
The bench targets the following corner cases:
- A unicast address that differs from the station address only in its last bit. A comparator that is too narrow would accept it.
- Pairs of group addresses where the hash bit is set either at the true index or at the same position in the other register. A design that swaps the two registers, takes the wrong CRC bits, or adds a final inversion flips the result.
- Broadcast under each mode. This catches broadcast being routed through the hash or left unaffected by its own mode bit.
- Idle gaps between bytes, extra bytes after the sixth, and a bare start strobe. A counter that does not stop or does not restart would corrupt or drop the held result.

// File: rtl/rx_da_filter.sv
module rx_da_filter #(
  parameter logic [31:0] CRC_POLY = 32'hEDB88320,
  parameter logic [31:0] CRC_INIT = 32'hFFFF_FFFF,
  parameter logic [3:0]  MODE_RST = 4'b1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        da_start,
  input  logic        da_valid,
  input  logic [7:0]  da_byte,
  output logic        dec_valid,
  output logic        dec_accept,
  output logic        dec_ucast,
  output logic        dec_mcast,
  output logic        dec_bcast
);
  localparam int NBYTES = 6;
  localparam int CW = $clog2(NBYTES + 1);
  localparam logic [CW-1:0] LAST = CW'(NBYTES - 1);
  localparam logic [CW-1:0] DONE = CW'(NBYTES);

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r >> 1) ^ ((r[0] ^ d[i]) ? CRC_POLY : 32'h0);
    return r;
  endfunction

  logic [15:0] sta_hi;
  logic [31:0] sta_lo, hash_lo, hash_hi;
  logic [3:0]  mode;
  logic [CW-1:0] cnt;
  logic [31:0] crc;
  logic [8*(NBYTES-1)-1:0] head;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sta_hi  <= '0;
      sta_lo  <= '0;
      hash_lo <= '0;
      hash_hi <= '0;
      mode    <= MODE_RST;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: sta_hi  <= cfg_wdata[15:0];
        3'd1: sta_lo  <= cfg_wdata;
        3'd2: hash_lo <= cfg_wdata;
        3'd3: hash_hi <= cfg_wdata;
        3'd4: mode    <= cfg_wdata[3:0];
        default: ;
      endcase
    end
  end

  wire [CW-1:0] cnt_eff = da_start ? '0 : cnt;
  wire [31:0]   crc_eff = da_start ? CRC_INIT : crc;
  wire          take    = da_valid && (cnt_eff < DONE);
  wire          last    = take && (cnt_eff == LAST);
  wire [31:0]   crc_nxt = crc_step(crc_eff, da_byte);
  wire [47:0]   addr    = {head, da_byte};
  wire [47:0]   station = {sta_hi, sta_lo};

  wire       is_bc   = &addr;
  wire       is_grp  = addr[40];
  wire       is_mc   = is_grp && !is_bc;
  wire       is_uc   = !is_grp;
  wire [5:0] idx     = crc_nxt[31:26];
  wire       hbit    = idx[5] ? hash_hi[idx[4:0]] : hash_lo[idx[4:0]];
  wire       acc     = mode[0]
                     || (is_uc && (addr == station))
                     || (is_bc && mode[3])
                     || (is_grp && mode[1])
                     || (is_mc && mode[2] && hbit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      crc        <= CRC_INIT;
      head       <= '0;
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_ucast  <= 1'b0;
      dec_mcast  <= 1'b0;
      dec_bcast  <= 1'b0;
    end else begin
      if (da_start) dec_valid <= 1'b0;
      if (take) begin
        cnt  <= cnt_eff + 1'b1;
        crc  <= crc_nxt;
        head <= {head[8*(NBYTES-2)-1:0], da_byte};
      end else begin
        cnt <= cnt_eff;
        crc <= crc_eff;
      end
      if (last) begin
        dec_valid  <= 1'b1;
        dec_accept <= acc;
        dec_ucast  <= is_uc;
        dec_mcast  <= is_mc;
        dec_bcast  <= is_bc;
      end
    end
  end
endmodule

module rx_da_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       da_start,
  input logic       da_valid,
  input logic [3:0] mode,
  input logic       dec_valid,
  input logic       dec_accept,
  input logic       dec_ucast,
  input logic       dec_mcast,
  input logic       dec_bcast
);
  assert_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    da_start |=> !dec_valid);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !da_start) |=> (dec_valid && $stable(dec_accept) && $stable(dec_ucast)
                                  && $stable(dec_mcast) && $stable(dec_bcast)));
  assert_one_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> ($countones({dec_ucast, dec_mcast, dec_bcast}) == 1));
  assert_promisc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dec_valid) && $past(mode[0])) |-> dec_accept);
  assert_bcast_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dec_valid) && dec_bcast && $past(mode[3])) |-> dec_accept);
  assert_byte_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) |-> $past(da_valid));
endmodule

bind rx_da_filter rx_da_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .da_start(da_start), .da_valid(da_valid), .mode(mode),
  .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_ucast(dec_ucast),
  .dec_mcast(dec_mcast), .dec_bcast(dec_bcast)
);

// File: tb/sim_rx_da_filter.sv
`timescale 1ns/1ps
module sim_rx_da_filter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic da_start = 1'b0, da_valid = 1'b0;
  logic [7:0] da_byte = '0;
  logic dec_valid, dec_accept, dec_ucast, dec_mcast, dec_bcast;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rx_da_filter u0 (.*);

  localparam logic [47:0] STA = 48'h02_11_22_33_44_55;
  // {address, mode, hash setting: 0 none, 1 true index, 2 same bit in other register}
  localparam int NV = 15;
  localparam logic [53:0] VEC [NV] = '{
    {48'h02_11_22_33_44_55, 4'h0, 2'd0},
    {48'h02_11_22_33_44_66, 4'h0, 2'd0},
    {48'h02_11_22_33_44_54, 4'h0, 2'd0},
    {48'h0A_0B_0C_0D_0E_0F, 4'h1, 2'd0},
    {48'hFF_FF_FF_FF_FF_FF, 4'h8, 2'd0},
    {48'hFF_FF_FF_FF_FF_FF, 4'h0, 2'd0},
    {48'hFF_FF_FF_FF_FF_FF, 4'h2, 2'd0},
    {48'h01_00_5E_00_00_01, 4'h0, 2'd0},
    {48'h01_00_5E_00_00_01, 4'h2, 2'd0},
    {48'h01_00_5E_00_00_01, 4'h4, 2'd1},
    {48'h01_00_5E_00_00_01, 4'h4, 2'd2},
    {48'h33_33_00_00_00_01, 4'h4, 2'd1},
    {48'h33_33_00_00_00_01, 4'h4, 2'd2},
    {48'h33_33_00_00_00_01, 4'h0, 2'd1},
    {48'h02_11_22_33_44_55, 4'hC, 2'd0}
  };

  logic [31:0] m_hlo, m_hhi;
  logic [3:0]  m_mode;

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++)
      for (int i = 0; i < 8; i++) begin
        logic bitv = a[47 - 8*b - 7 + i];
        c = (c >> 1) ^ ((c[0] ^ bitv) ? 32'hEDB88320 : 32'h0);
      end
    return c[31:26];
  endfunction

  function automatic logic ref_acc(input logic [47:0] a);
    logic bc = &a, grp = a[40];
    logic [5:0] ix = ref_idx(a);
    logic hb = ix[5] ? m_hhi[ix[4:0]] : m_hlo[ix[4:0]];
    return m_mode[0] || (!grp && a == STA) || (bc && m_mode[3]) || (grp && m_mode[1])
           || (grp && !bc && m_mode[2] && hb);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
    if (a == 3'd2) m_hlo = d;
    if (a == 3'd3) m_hhi = d;
    if (a == 3'd4) m_mode = d[3:0];
  endtask

  task automatic send(input logic [47:0] a, input int gap);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); da_start = (i == 0); da_valid = 1'b1; da_byte = a[47 - 8*i -: 8];
      if (i < 5) for (int g = 0; g < gap; g++) begin
        @(negedge clk); da_start = 1'b0; da_valid = 1'b0; da_byte = 8'hA5;
      end
    end
    @(negedge clk); da_start = 1'b0; da_valid = 1'b0;
  endtask

  task automatic check_result(input string req, input logic [47:0] a);
    logic bc = &a;
    chk(req, {31'b0, dec_valid}, 32'd1);
    chk(req, {31'b0, dec_accept}, {31'b0, ref_acc(a)});
    chk("R5", {29'b0, dec_ucast, dec_mcast, dec_bcast}, {29'b0, !a[40], a[40] && !bc, bc});
  endtask

  task automatic set_hash(input logic [47:0] a, input logic [1:0] sel);
    logic [5:0] ix = ref_idx(a);
    logic [31:0] bitm = 32'h1 << ix[4:0];
    logic [31:0] lo = 32'h0, hi = 32'h0;
    if (sel == 2'd1) begin if (ix[5]) hi = bitm; else lo = bitm; end
    if (sel == 2'd2) begin if (ix[5]) lo = bitm; else hi = bitm; end
    wr(3'd2, lo);
    wr(3'd3, hi);
  endtask

  initial begin
    m_hlo = '0; m_hhi = '0; m_mode = 4'b1000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state
    chk("R2", {27'b0, dec_valid, dec_accept, dec_ucast, dec_mcast, dec_bcast}, 32'd0);
    send(48'hFF_FF_FF_FF_FF_FF, 0);
    chk("R2", {31'b0, dec_accept}, 32'd1);
    send(48'h01_00_5E_00_00_09, 0);
    chk("R2", {31'b0, dec_accept}, 32'd0);

    // R1: station registers
    wr(3'd0, {16'hDEAD, STA[47:32]});
    wr(3'd1, STA[31:0]);

    for (int v = 0; v < NV; v++) begin
      set_hash(VEC[v][53:6], VEC[v][1:0]);
      wr(3'd4, {28'b0, VEC[v][5:2]});
      send(VEC[v][53:6], v % 3);
      check_result($sformatf("R6/R7/R8/R9/R10 row %0d", v), VEC[v][53:6]);
    end

    // R11: register half selection
    wr(3'd4, 32'h4);
    for (int k = 0; k < 8; k++) begin
      logic [47:0] a = {40'h01_00_5E_00_00, 8'(k * 37)};
      set_hash(a, 2'd1);
      send(a, 0);
      chk("R11", {31'b0, dec_accept}, 32'd1);
      set_hash(a, 2'd2);
      send(a, 0);
      chk("R11", {31'b0, dec_accept}, 32'd0);
    end

    // R4: hold, extra bytes ignored (R3), start clears
    wr(3'd4, 32'h0);
    send(STA, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); da_valid = 1'b1; da_byte = 8'hFF;
    end
    @(negedge clk); da_valid = 1'b0;
    chk("R3", {30'b0, dec_valid, dec_accept}, 32'd3);
    chk("R4", {29'b0, dec_ucast, dec_mcast, dec_bcast}, 32'd4);
    @(negedge clk); da_start = 1'b1;
    @(negedge clk); da_start = 1'b0;
    chk("R4", {31'b0, dec_valid}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R4", {31'b0, dec_valid}, 32'd0);
    send(48'h02_11_22_33_44_56, 4);
    chk("R6", {30'b0, dec_valid, dec_accept}, 32'd2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule